// File: doc/BRIEF.md
# Low-Power Real-Time Counter with Register Access

This block keeps a 47-bit running count of a 32.768 kHz time base. The slow tick arrives as a one-cycle enable, `tickEn`, that is synchronous to the bus clock. Each asserted tick adds one to the count, so the count holds seconds in its upper bits and fractions of a second in its lower 15 bits.

Software reaches the block through a plain 32-bit register bus. The bus has a byte address, a write strobe with write data, and a read strobe with registered read data. The count is seen through two windows:

- The lower window holds the low 32 bits of the count.
- The upper window holds the remaining 15 bits of the count.

Software may load either window, and the other window keeps its value.

A control word is also held in the block and reads back as it was written. When a write to the control word sets its turn-off bit and its power-down-enable bit together, the block issues a one-cycle power-off request to the system. A register-block reset clears the control word. A reset does not clear the count, so the time survives a reset of the bus logic.

Top module: `lp_rtc_top`

## Requirements
- R1: Every clock cycle with `tickEn` high and no count write increments the 47-bit count by one. A cycle with `tickEn` low and no count write leaves the count unchanged.
- R2: A read of byte address 0x54 returns count bits 31:0. Read data is registered: it appears after the clock edge that samples `busRe`, holds the count as it was before that edge, and stays until the next read.
- R3: A read of byte address 0x50 returns count bits 46:32 in data bits 14:0, with data bits 31:15 zero.
- R4: A write to address 0x54 loads count bits 31:0 from the write data and leaves count bits 46:32 unchanged.
- R5: A write to address 0x50 loads count bits 46:32 from write data bits 14:0 and leaves count bits 31:0 unchanged. Write data bits 31:15 are ignored.
- R6: When a count write and a tick occur in the same cycle, the written value is stored and that tick is lost.
- R7: The control word at address 0x38 reads back all 32 bits last written to it. Reset clears it to zero.
- R8: A write to address 0x38 whose data has bit 6 (turn-off) and bit 5 (power-down enable) both set raises `powerOffReq`. The request is high for exactly one cycle, after the edge that captures the write. Any other control write raises no request.
- R9: A read of any other address returns zero. A write to any other address changes neither the count nor the control word, and raises no request.
- R10: Reset leaves the count unchanged. At power-on the count starts at the parameter `INIT_COUNT`. Reset clears `busRdata` and `powerOffReq` to zero.
- R11: The count wraps from 2^47-1 to zero on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset of the register logic (the count is not reset) |
| tickEn | input | 1 | 32.768 kHz tick enable, one cycle per count |
| busAddr | input | ADDR_W (12) | Byte address |
| busWe | input | 1 | Write strobe |
| busWdata | input | DATA_W (32) | Write data |
| busRe | input | 1 | Read strobe |
| busRdata | output | DATA_W (32) | Registered read data |
| powerOffReq | output | 1 | One-cycle power-off request |

## Verification
A count that drops or duplicates a tick shows as a wrong lower window on the next read. It is caught within one read of the faulty cycle, because the bench reads the count after every short tick pattern. A carry that fails to cross bit 31, or a half-write that disturbs the other window, shows on the upper window read that follows the load. A control decode error shows either as a request pulse in the very next cycle where none belongs, or as a missing pulse.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_HI   = 2'd2,
    SEL_LO   = 2'd3
  } rtcSel_e;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic    wrHi;
    logic    wrLo;
    logic    rdEn;
    rtcSel_e rdSel;
  } rtcStrobe_t;

endpackage

// File: rtl/lp_rtc_ctrl.sv
module lp_rtc_ctrl
  import lp_rtc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int CTRL_OFF = 'h38,
  parameter int HI_OFF   = 'h50,
  parameter int LO_OFF   = 'h54,
  parameter int OFF_BIT  = 6,
  parameter int PDEN_BIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  output rtcStrobe_t        strb,
  output logic [DATA_W-1:0] ctrlVal,
  output logic              powerOffReq
);

  localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] HiAddr   = ADDR_W'(HI_OFF);
  localparam logic [ADDR_W-1:0] LoAddr   = ADDR_W'(LO_OFF);

  logic hitCtrl, hitHi, hitLo;
  logic [DATA_W-1:0] ctrlReg;
  logic offPulse;
  logic shutdownCombo;

  assign hitCtrl = (busAddr == CtrlAddr);
  assign hitHi   = (busAddr == HiAddr);
  assign hitLo   = (busAddr == LoAddr);

  always_comb begin
    strb.wrHi  = busWe & hitHi;
    strb.wrLo  = busWe & hitLo;
    strb.rdEn  = busRe;
    strb.rdSel = hitCtrl ? SEL_CTRL :
                 hitHi   ? SEL_HI   :
                 hitLo   ? SEL_LO   : SEL_NONE;
  end

  assign shutdownCombo = busWdata[OFF_BIT] & busWdata[PDEN_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      offPulse <= 1'b0;
    end else begin
      if (busWe && hitCtrl) ctrlReg <= busWdata;
      offPulse <= busWe & hitCtrl & shutdownCombo;
    end
  end

  assign ctrlVal     = ctrlReg;
  assign powerOffReq = offPulse;

  // R8: a pulse lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    powerOffReq |=> !powerOffReq);

  // R8: a pulse appears only when the stored control word carries both bits
  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerOffReq) |-> (ctrlVal[OFF_BIT] && ctrlVal[PDEN_BIT]));

  // R9: decoded windows never overlap
  a_r9_decode_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hitCtrl, hitHi, hitLo}));

  // R7: the control word moves only on a control write
  a_r7_ctrl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && hitCtrl) |=> $stable(ctrlVal));

endmodule

// File: rtl/lp_rtc_datapath.sv
module lp_rtc_datapath
  import lp_rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 47,
  parameter logic [CNT_W-1:0] INIT_COUNT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [DATA_W-1:0] wdata,
  input  rtcStrobe_t        strb,
  input  logic [DATA_W-1:0] ctrlVal,
  output logic [DATA_W-1:0] rdata
);

  localparam int HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0]  count = INIT_COUNT;
  logic [CNT_W-1:0]  countNxt;
  logic [DATA_W-1:0] hiView;
  logic [DATA_W-1:0] rdataReg;

  // Write wins over tick; the count has no reset
  always_comb begin
    countNxt = count;
    if (strb.wrHi)      countNxt[CNT_W-1:DATA_W] = wdata[HI_W-1:0];
    else if (strb.wrLo) countNxt[DATA_W-1:0]     = wdata;
    else if (tickEn)    countNxt                 = count + 1'b1;
  end

  always_ff @(posedge clk) begin
    count <= countNxt;
  end

  assign hiView = DATA_W'(count[CNT_W-1:DATA_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataReg <= '0;
    end else if (strb.rdEn) begin
      case (strb.rdSel)
        SEL_CTRL: rdataReg <= ctrlVal;
        SEL_HI:   rdataReg <= hiView;
        SEL_LO:   rdataReg <= count[DATA_W-1:0];
        default:  rdataReg <= '0;
      endcase
    end
  end

  assign rdata = rdataReg;

  // R1: idle cycles keep the count
  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strb.wrHi && !strb.wrLo) |=> $stable(count));

  // R1 / R11: a bare tick adds one, modulo the count width
  a_r1_tick: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !strb.wrHi && !strb.wrLo) |=> (count == $past(count) + 1'b1));

  // R4: low load keeps the upper part
  a_r4_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLo |=> (count[CNT_W-1:DATA_W] == $past(count[CNT_W-1:DATA_W])));

  // R5: upper load keeps the low part
  a_r5_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrHi |=> (count[DATA_W-1:0] == $past(count[DATA_W-1:0])));

  // R6: a tick coinciding with a low load is lost
  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrLo && tickEn) |=> (count[DATA_W-1:0] == $past(wdata)));

  // R9: unmapped reads give zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdSel == SEL_NONE) |=> (rdata == '0));

  // R3: upper window has zero padding
  a_r3_hi_pad: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdSel == SEL_HI) |=> (rdata[DATA_W-1:HI_W] == '0));

endmodule

// File: rtl/lp_rtc_top.sv
module lp_rtc_top
  import lp_rtc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 47,
  parameter int CTRL_OFF = 'h38,
  parameter int HI_OFF   = 'h50,
  parameter int LO_OFF   = 'h54,
  parameter int OFF_BIT  = 6,
  parameter int PDEN_BIT = 5,
  parameter logic [CNT_W-1:0] INIT_COUNT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  output logic              powerOffReq
);

  rtcStrobe_t        strb;
  logic [DATA_W-1:0] ctrlVal;

  lp_rtc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFF(CTRL_OFF),
    .HI_OFF(HI_OFF), .LO_OFF(LO_OFF), .OFF_BIT(OFF_BIT), .PDEN_BIT(PDEN_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .strb(strb), .ctrlVal(ctrlVal),
    .powerOffReq(powerOffReq)
  );

  lp_rtc_datapath #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .INIT_COUNT(INIT_COUNT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wdata(busWdata),
    .strb(strb), .ctrlVal(ctrlVal), .rdata(busRdata)
  );

endmodule

// File: tb/lp_rtc_top_tb.sv
module lp_rtc_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic        powerOffReq;

  int checks = 0;
  int failures = 0;
  logic [46:0] expCount = '0;
  logic [31:0] rd;
  logic        pulse;
  bit          done = 0;

  always #10 clk = ~clk;

  lp_rtc_top u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRe(busRe),
    .busRdata(busRdata), .powerOffReq(powerOffReq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Write; returns powerOffReq seen after the capturing edge
  task automatic busWrite(input logic [11:0] a, input logic [31:0] d, output logic p);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
    p = powerOffReq;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  task automatic tickCycles(input logic [7:0] pat, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickEn = pat[i];
      if (pat[i]) expCount = expCount + 1'b1;
    end
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic checkCount(input string req);
    busRead(12'h054, rd);
    check(req, rd, expCount[31:0]);
    busRead(12'h050, rd);
    check(req, rd, {17'd0, expCount[46:32]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state of outputs
    check("R10 rdata reset", busRdata, 0);
    check("R10 pulse reset", powerOffReq, 0);
    rstN = 1'b1;
    // R7: control cleared
    busRead(12'h038, rd);
    check("R7 ctrl reset", rd, 0);
    // R10: power-on count
    checkCount("R10 init count");

    // R1 / R2: sweep all 8-cycle tick patterns
    for (int p = 0; p < 256; p++) begin
      tickCycles(p[7:0], 8);
      busRead(12'h054, rd);
      check("R1 R2 tick sweep", rd, expCount[31:0]);
    end

    // R4 / R5 / R3: half loads, carry into upper part
    busWrite(12'h054, 32'hFFFF_FFFE, pulse); expCount[31:0] = 32'hFFFF_FFFE;
    check("R4 lo load", 0, 0);
    busWrite(12'h050, 32'hFFFF_1234, pulse); expCount[46:32] = 15'h1234;
    checkCount("R5 hi load ignores upper wdata");
    tickCycles(8'h07, 3);
    checkCount("R1 carry into hi");
    busWrite(12'h054, 32'h0BAD_F00D, pulse); expCount[31:0] = 32'h0BAD_F00D;
    checkCount("R4 lo load keeps hi");
    busWrite(12'h050, 32'h0000_2222, pulse); expCount[46:32] = 15'h2222;
    checkCount("R5 hi load keeps lo");

    // R6: write and tick together
    @(negedge clk);
    busAddr = 12'h054; busWe = 1'b1; busWdata = 32'h1111_0000; tickEn = 1'b1;
    @(negedge clk);
    busWe = 1'b0; tickEn = 1'b0; expCount[31:0] = 32'h1111_0000;
    checkCount("R6 lo write beats tick");
    @(negedge clk);
    busAddr = 12'h050; busWe = 1'b1; busWdata = 32'h0000_0005; tickEn = 1'b1;
    @(negedge clk);
    busWe = 1'b0; tickEn = 1'b0; expCount[46:32] = 15'h0005;
    checkCount("R6 hi write beats tick");

    // R11: wrap
    busWrite(12'h050, 32'h0000_7FFF, pulse);
    busWrite(12'h054, 32'hFFFF_FFFF, pulse);
    expCount = '1;
    tickCycles(8'h01, 1);
    checkCount("R11 wrap to zero");

    // R7 / R8: sweep the two control bits
    for (int c = 0; c < 4; c++) begin
      logic [31:0] w;
      w = 32'hA500_0000 | (32'(c[1]) << 6) | (32'(c[0]) << 5) | 32'h3;
      busWrite(12'h038, w, pulse);
      check("R8 pulse after write", pulse, (c == 3));
      @(negedge clk);
      check("R8 pulse one cycle", powerOffReq, 0);
      busRead(12'h038, rd);
      check("R7 ctrl readback", rd, w);
    end

    // R9: unmapped addresses
    busWrite(12'h040, 32'hFFFF_FFFF, pulse);
    check("R9 no pulse unmapped", pulse, 0);
    busWrite(12'h058, 32'h0000_0060, pulse);
    check("R9 no pulse unmapped", pulse, 0);
    busWrite(12'h138, 32'h0000_0060, pulse);
    check("R9 alias no pulse", pulse, 0);
    busRead(12'h040, rd);
    check("R9 unmapped read zero", rd, 0);
    busRead(12'h038, rd);
    check("R9 ctrl untouched", rd, 32'hA500_0063);
    checkCount("R9 count untouched");

    // R2: read data holds between reads
    busRead(12'h054, rd);
    tickCycles(8'h0F, 4);
    check("R2 rdata holds", busRdata, rd);
    checkCount("R2 after ticks");

    // R10: reset keeps the count, clears control
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 rdata cleared", busRdata, 0);
    rstN = 1'b1;
    checkCount("R10 count survives reset");
    busRead(12'h038, rd);
    check("R7 ctrl cleared by reset", rd, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule